// File: doc/BRIEF.md
# Three-Rail Power Sequencing Controller

This block raises three power-good style flags one after another when its enable input goes high, and lowers them again in a programmed order when enable goes low. Each of the six steps (three rising, three falling) waits a programmable number of ticks before its flag changes. All timing is counted on a single-cycle `tick` strobe that the surrounding logic supplies at a fixed rate (100 µs by default), so the block itself is independent of the system clock frequency.

The delay of each step is a 4-bit index multiplied by a step size that is common to all six steps. A 2-bit column select picks the step size, and a single bit picks whether the flags fall in the same order they rose or in the opposite order. Configuration is captured when a sequence begins and stays fixed until the block is back in idle. If enable is withdrawn after the first flag is already up but before the last one is, the block restarts the step in progress, completes the power-up, lets the rails settle for a fixed interval and then powers down.

Top module: `rail_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge it is sampled low, all three flags are driven low and the block returns to idle.
- R2: From idle with `enable` high, flags rise strictly in the order bit 0, bit 1, bit 2 of `rail_flags`; bit k rises on the clock edge after timer k+1 has counted its programmed number of ticks, and a programmed delay of zero ticks takes one clock.
- R3: The delay of every step is index × step ticks, where index is the step's 4-bit field (timer k+1 uses bits [4k+3:4k] of `up_idx` or `dn_idx`) and the step is 20, 40, 60 or 80 ticks for `col_sel` = 0, 1, 2, 3; one `col_sel` applies to all six steps.
- R4: The first power-up step and the first power-down step each last 4 ticks longer than their programmed value.
- R5: With `rev_down` = 0 the flags fall in the order bit 0, bit 1, bit 2; with `rev_down` = 1 they fall in the order bit 2, bit 1, bit 0; the first fall begins counting on the edge that samples `enable` low with all flags up.
- R6: If `enable` is sampled low while the first power-up step is still counting, the block returns to idle with all flags low and no flag ever rises.
- R7: If `enable` falls while the second or third power-up step is counting, that step restarts from zero ticks, power-up completes, a 1200-tick settle interval follows the last rise, and the power-down sequence then runs even if `enable` has risen again.
- R8: A rising `enable` during power-down has no effect until all flags are low; a new power-up starts from idle on the next edge that samples `enable` high.
- R9: `col_sel`, `rev_down`, `up_idx` and `dn_idx` are captured when leaving idle; changes while a sequence runs do not alter its timing or order.
- R10: Delays advance only on cycles where `tick` is high; with `tick` low no step completes unless its delay is zero.
- R11: At most one flag changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base strobe, one cycle per tick period |
| enable | input | 1 | High requests power-up, low requests power-down |
| col_sel | input | 2 | Step-size column select for all six delays |
| rev_down | input | 1 | 1 lowers flags in reverse of their rising order |
| up_idx | input | 12 | Power-up delay indices, timer 1 in bits [3:0] |
| dn_idx | input | 12 | Power-down delay indices, timer 4 in bits [3:0] |
| rail_flags | output | 3 | Power-good flags, bit 0 is the first rail |

## Verification
With `tick` high every cycle, the first flag rises D1+2 clock edges after `enable` is driven high (one edge to leave idle, D1 counting edges, one edge to act), and each later step lands D+1 edges after the previous flag change; the first fall likewise lands D4+2 edges after `enable` drops, and in the controlled shutdown the first fall lands D4+1202 edges after the last rise. The bench drives every stimulus just after a falling clock edge, counts rising edges and samples `rail_flags` on the following falling edge, so each measured count is compared with the value computed from the delay formula. Waiting for a whole flag pattern rather than a single bit also catches a wrong order, since a wrong pattern never matches and the count runs out.

// File: rtl/rail_seq_pkg.sv
// Shared types for the rail sequencer.
// Assumes: nothing beyond the state set below.
package rail_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_RISE   = 3'd1,
        SEQ_ALLUP  = 3'd2,
        SEQ_SETTLE = 3'd3,
        SEQ_FALL   = 3'd4
    } seq_state_e;

endpackage

// File: rtl/rail_seq_delay_map.sv
// Converts captured delay indices into tick counts for every step.
// Assumes: CNT_W holds the largest index times the largest step plus EXTRA_TICKS.
module rail_seq_delay_map #(
    parameter int NUM_RAILS    = 3,
    parameter int IDX_W        = 4,
    parameter int STEP_BASE    = 20,
    parameter int EXTRA_TICKS  = 4,
    parameter int CNT_W        = 11
) (
    input  logic [1:0]                       col,
    input  logic [NUM_RAILS*IDX_W-1:0]       rise_idx,
    input  logic [NUM_RAILS*IDX_W-1:0]       fall_idx,
    output logic [NUM_RAILS-1:0][CNT_W-1:0]  rise_dly,
    output logic [NUM_RAILS-1:0][CNT_W-1:0]  fall_dly
);

    logic [CNT_W-1:0] step_ticks;

    // Step size grows linearly with the column number.
    always_comb step_ticks = CNT_W'((32'(col) + 32'd1) * 32'(STEP_BASE));

    for (genvar k = 0; k < NUM_RAILS; k++) begin : g_dly
        localparam int ADD = (k == 0) ? EXTRA_TICKS : 0;
        assign rise_dly[k] = CNT_W'(32'(rise_idx[k*IDX_W +: IDX_W]) * 32'(step_ticks))
                             + CNT_W'(ADD);
        assign fall_dly[k] = CNT_W'(32'(fall_idx[k*IDX_W +: IDX_W]) * 32'(step_ticks))
                             + CNT_W'(ADD);
    end

endmodule

// File: rtl/rail_seq_timer.sv
// Counts ticks up to a target; done is high once the count equals the target.
// Assumes: the owner pulses clear when a step starts or restarts.
module rail_seq_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             done
);

    logic [CNT_W-1:0] count;

    assign done = (count == target);

    // Advance on each tick until the target is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (tick && !done) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rail_seq_fsm.sv
// Sequencing control: rise steps, settle, fall steps, abort and controlled shutdown.
// Assumes: tmr_done reflects the target selected for the current state and step.
module rail_seq_fsm
    import rail_seq_pkg::*;
#(
    parameter int NUM_RAILS = 3,
    parameter int STEP_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 tmr_done,
    input  logic                 rev_q,
    output seq_state_e           state,
    output logic [STEP_W-1:0]    step,
    output logic [NUM_RAILS-1:0] flags,
    output logic                 tmr_clear,
    output logic                 cfg_load
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_RAILS - 1);

    logic              en_q;
    logic              shut_pend;
    logic              en_fall;
    logic [STEP_W-1:0] fall_sel;

    assign en_fall  = en_q && !enable;
    assign fall_sel = rev_q ? (LAST - step) : step;
    assign cfg_load = (state == SEQ_IDLE) && enable;

    // Restart the timer on every step boundary, abort or enable fall.
    always_comb begin
        unique case (state)
            SEQ_IDLE, SEQ_ALLUP: tmr_clear = 1'b1;
            SEQ_RISE:  tmr_clear = ((step == '0) && !enable)
                                   || ((step != '0) && en_fall) || tmr_done;
            SEQ_SETTLE, SEQ_FALL: tmr_clear = tmr_done;
            default:   tmr_clear = 1'b1;
        endcase
    end

    // State, step and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            step      <= '0;
            flags     <= '0;
            shut_pend <= 1'b0;
            en_q      <= 1'b0;
        end else begin
            en_q <= enable;
            unique case (state)
                SEQ_IDLE: begin
                    shut_pend <= 1'b0;
                    step      <= '0;
                    if (enable) state <= SEQ_RISE;
                end
                SEQ_RISE: begin
                    if ((step == '0) && !enable) begin
                        state <= SEQ_IDLE;
                        flags <= '0;
                    end else if ((step != '0) && en_fall) begin
                        shut_pend <= 1'b1;
                    end else if (tmr_done) begin
                        flags[step] <= 1'b1;
                        if (step == LAST) begin
                            step  <= '0;
                            state <= shut_pend ? SEQ_SETTLE : SEQ_ALLUP;
                        end else begin
                            step <= step + STEP_W'(1);
                        end
                    end
                end
                SEQ_ALLUP: begin
                    if (!enable) begin
                        step  <= '0;
                        state <= SEQ_FALL;
                    end
                end
                SEQ_SETTLE: begin
                    if (tmr_done) begin
                        step  <= '0;
                        state <= SEQ_FALL;
                    end
                end
                SEQ_FALL: begin
                    if (tmr_done) begin
                        flags[fall_sel] <= 1'b0;
                        if (step == LAST) begin
                            step  <= '0;
                            state <= SEQ_IDLE;
                        end else begin
                            step <= step + STEP_W'(1);
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rail_sequencer.sv
// Top of the three-rail sequencer: captures configuration, maps delays,
// selects the active timer target and wires the controller.
// Assumes: tick is a one-cycle strobe at the tick period; inputs are synchronous.
module rail_sequencer
    import rail_seq_pkg::*;
#(
    parameter int NUM_RAILS    = 3,
    parameter int IDX_W        = 4,
    parameter int TICKS_PER_MS = 10,
    parameter int BASE_STEP_MS = 2,
    parameter int EXTRA_TICKS  = 4,
    parameter int SETTLE_TICKS = 1200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       enable,
    input  logic [1:0]                 col_sel,
    input  logic                       rev_down,
    input  logic [NUM_RAILS*IDX_W-1:0] up_idx,
    input  logic [NUM_RAILS*IDX_W-1:0] dn_idx,
    output logic [NUM_RAILS-1:0]       rail_flags
);

    localparam int STEP_BASE = BASE_STEP_MS * TICKS_PER_MS;
    localparam int MAX_PROG  = ((1 << IDX_W) - 1) * 4 * STEP_BASE + EXTRA_TICKS;
    localparam int MAX_TGT   = (MAX_PROG > SETTLE_TICKS) ? MAX_PROG : SETTLE_TICKS;
    localparam int CNT_W     = $clog2(MAX_TGT + 1);
    localparam int STEP_W    = (NUM_RAILS > 2) ? $clog2(NUM_RAILS) : 1;

    seq_state_e                      state;
    logic [STEP_W-1:0]               step;
    logic                            tmr_clear;
    logic                            tmr_done;
    logic                            cfg_load;
    logic [CNT_W-1:0]                target;
    logic [1:0]                      cfg_col_q;
    logic                            cfg_rev_q;
    logic [NUM_RAILS*IDX_W-1:0]      cfg_up_q;
    logic [NUM_RAILS*IDX_W-1:0]      cfg_dn_q;
    logic [NUM_RAILS-1:0][CNT_W-1:0] rise_dly;
    logic [NUM_RAILS-1:0][CNT_W-1:0] fall_dly;

    // Capture configuration as a sequence leaves idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_col_q <= '0;
            cfg_rev_q <= 1'b0;
            cfg_up_q  <= '0;
            cfg_dn_q  <= '0;
        end else if (cfg_load) begin
            cfg_col_q <= col_sel;
            cfg_rev_q <= rev_down;
            cfg_up_q  <= up_idx;
            cfg_dn_q  <= dn_idx;
        end
    end

    rail_seq_delay_map #(
        .NUM_RAILS   (NUM_RAILS),
        .IDX_W       (IDX_W),
        .STEP_BASE   (STEP_BASE),
        .EXTRA_TICKS (EXTRA_TICKS),
        .CNT_W       (CNT_W)
    ) u_map (
        .col      (cfg_col_q),
        .rise_idx (cfg_up_q),
        .fall_idx (cfg_dn_q),
        .rise_dly (rise_dly),
        .fall_dly (fall_dly)
    );

    // Pick the delay that belongs to the current state and step.
    always_comb begin
        unique case (state)
            SEQ_RISE:   target = rise_dly[step];
            SEQ_FALL:   target = fall_dly[step];
            SEQ_SETTLE: target = CNT_W'(SETTLE_TICKS);
            default:    target = '0;
        endcase
    end

    rail_seq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .tick   (tick),
        .target (target),
        .done   (tmr_done)
    );

    rail_seq_fsm #(
        .NUM_RAILS (NUM_RAILS),
        .STEP_W    (STEP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tmr_done  (tmr_done),
        .rev_q     (cfg_rev_q),
        .state     (state),
        .step      (step),
        .flags     (rail_flags),
        .tmr_clear (tmr_clear),
        .cfg_load  (cfg_load)
    );

endmodule

// File: rtl/rail_sequencer_chk.sv
// Temporal checks on the sequencer's flags, bound into rail_sequencer.
// Assumes: rev_q is the captured fall-order bit, stable during a sequence.
module rail_sequencer_chk #(
    parameter int NUM_RAILS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic                 rev_q,
    input logic [NUM_RAILS-1:0] flags
);

    logic past_ok;

    // Marks cycles whose previous sample was taken out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R11
    one_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ($countones(flags ^ $past(flags)) <= 1));

    // R6
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(flags[0])) |-> $past(enable));

    for (genvar k = 1; k < NUM_RAILS; k++) begin : g_order
        // R2
        up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $rose(flags[k])) |-> flags[k-1]);
        // R5
        fwd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && !rev_q && $fell(flags[k])) |-> !flags[k-1]);
        // R5
        rev_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && rev_q && $fell(flags[k-1])) |-> !flags[k]);
    end

endmodule

bind rail_sequencer rail_sequencer_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .rev_q  (cfg_rev_q),
    .flags  (rail_flags)
);

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 190000;
    localparam int NVEC       = 5;

    // {col_sel, rev_down, up_idx, dn_idx}; nibble 0 of each index field is timer 1/4.
    localparam logic [26:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 12'h321, 12'h201},
        {2'd1, 1'b1, 12'h050, 12'h130},
        {2'd2, 1'b0, 12'h214, 12'h222},
        {2'd3, 1'b1, 12'hFFF, 12'hF0F},
        {2'd0, 1'b1, 12'h000, 12'h000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        enable = 1'b0;
    logic [1:0]  col_sel = 2'd0;
    logic        rev_down = 1'b0;
    logic [11:0] up_idx = '0;
    logic [11:0] dn_idx = '0;
    logic [2:0]  rail_flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit ended  = 1'b0;

    rail_sequencer u_rail_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .enable     (enable),
        .col_sel    (col_sel),
        .rev_down   (rev_down),
        .up_idx     (up_idx),
        .dn_idx     (dn_idx),
        .rail_flags (rail_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is counted as a failure and still summarised.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !ended) begin
            ended = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int dly(logic [1:0] c, logic [3:0] i, bit first);
        return int'(i) * (int'(c) + 1) * 20 + (first ? 4 : 0);
    endfunction

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_pat(logic [2:0] pat, output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while (rail_flags !== pat && n < 6000);
    endtask

    task automatic expect_pat(logic [2:0] pat, int exp, string tag);
        int n;
        wait_pat(pat, n);
        check_int(tag, n, exp);
    endtask

    task automatic apply_cfg(logic [1:0] c, logic r, logic [11:0] u, logic [11:0] d);
        col_sel = c; rev_down = r; up_idx = u; dn_idx = d;
    endtask

    // Expects flags 001, 011, 111; first_off is the offset of the first step.
    task automatic run_up(logic [1:0] c, logic [11:0] u, int first_off, string tag);
        expect_pat(3'b001, dly(c, u[3:0], 1) + first_off, {tag, " R2 R4 flag0 rise"});
        expect_pat(3'b011, dly(c, u[7:4], 0) + 1, {tag, " R2 R3 flag1 rise"});
        expect_pat(3'b111, dly(c, u[11:8], 0) + 1, {tag, " R2 R3 flag2 rise"});
    endtask

    // Expects the three falls in the order chosen by r.
    task automatic run_down(logic [1:0] c, logic r, logic [11:0] d, int first_off, string tag);
        expect_pat(r ? 3'b011 : 3'b110, dly(c, d[3:0], 1) + first_off, {tag, " R5 R4 first fall"});
        expect_pat(r ? 3'b001 : 3'b100, dly(c, d[7:4], 0) + 1, {tag, " R5 second fall"});
        expect_pat(3'b000, dly(c, d[11:8], 0) + 1, {tag, " R5 third fall"});
    endtask

    initial begin
        int n;
        bit seen;

        // R1: reset holds flags low even with enable high.
        enable = 1'b1;
        repeat (5) @(negedge clk);
        check_int("R1 flags in reset", int'(rail_flags), 0);
        enable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 flags after reset", int'(rail_flags), 0);

        // Table walk over columns, orders and indices.
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  c;
            logic        r;
            logic [11:0] u;
            logic [11:0] d;
            {c, r, u, d} = VEC[v];
            apply_cfg(c, r, u, d);
            enable = 1'b1;
            run_up(c, u, 2, $sformatf("vec%0d", v));
            enable = 1'b0;
            run_down(c, r, d, 2, $sformatf("vec%0d", v));
            repeat (3) @(negedge clk);
        end

        // R9: inputs changed right after start do not alter the running sequence.
        apply_cfg(2'd0, 1'b0, 12'h213, 12'h121);
        enable = 1'b1;
        @(negedge clk);
        apply_cfg(2'd3, 1'b1, 12'hFFF, 12'hFFF);
        expect_pat(3'b001, dly(2'd0, 4'd3, 1) + 1, "R9 flag0 rise with captured cfg");
        expect_pat(3'b011, dly(2'd0, 4'd1, 0) + 1, "R9 flag1 rise");
        expect_pat(3'b111, dly(2'd0, 4'd2, 0) + 1, "R9 flag2 rise");
        enable = 1'b0;
        run_down(2'd0, 1'b0, 12'h121, 2, "R9");
        repeat (3) @(negedge clk);

        // R10: no progress without ticks.
        apply_cfg(2'd0, 1'b0, 12'h111, 12'h111);
        tick = 1'b0;
        enable = 1'b1;
        repeat (100) @(negedge clk);
        check_int("R10 flags with tick held low", int'(rail_flags), 0);
        tick = 1'b1;
        run_up(2'd0, 12'h111, 1, "R10");
        enable = 1'b0;
        run_down(2'd0, 1'b0, 12'h111, 2, "R10");
        repeat (3) @(negedge clk);

        // R6: enable withdrawn during timer 1 aborts to idle.
        apply_cfg(2'd3, 1'b0, 12'h112, 12'h111);
        enable = 1'b1;
        repeat (50) @(negedge clk);
        enable = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rail_flags != 3'b000) seen = 1'b1;
        end
        check_int("R6 no flag after abort", int'(seen), 0);
        enable = 1'b1;
        expect_pat(3'b001, dly(2'd3, 4'd2, 1) + 2, "R6 full timer 1 after abort");

        // R1: reset in mid-sequence clears flags on the next edge.
        rst_n = 1'b0;
        @(negedge clk);
        check_int("R1 flags after mid-sequence reset", int'(rail_flags), 0);
        enable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: enable falls in timer 2, rises again during settle.
        apply_cfg(2'd0, 1'b0, 12'h132, 12'h111);
        enable = 1'b1;
        expect_pat(3'b001, dly(2'd0, 4'd2, 1) + 2, "R7 flag0 rise");
        repeat (5) @(negedge clk);
        enable = 1'b0;
        expect_pat(3'b011, dly(2'd0, 4'd3, 0) + 2, "R7 timer 2 restarted by enable fall");
        expect_pat(3'b111, dly(2'd0, 4'd1, 0) + 1, "R7 power-up completes");
        repeat (100) @(negedge clk);
        check_int("R7 flags held during settle", int'(rail_flags), 7);
        enable = 1'b1;
        expect_pat(3'b110, dly(2'd0, 4'd1, 1) + 1202 - 100, "R7 fall after settle");
        expect_pat(3'b100, dly(2'd0, 4'd1, 0) + 1, "R7 second fall");
        expect_pat(3'b000, dly(2'd0, 4'd1, 0) + 1, "R7 third fall");
        // R8: enable already high, so a fresh power-up follows from idle.
        run_up(2'd0, 12'h132, 2, "R8 restart after shutdown");
        enable = 1'b0;
        run_down(2'd0, 1'b0, 12'h111, 2, "R8");
        repeat (3) @(negedge clk);

        // R8: enable rising during a normal power-down is ignored until idle.
        apply_cfg(2'd1, 1'b1, 12'h111, 12'h231);
        enable = 1'b1;
        run_up(2'd1, 12'h111, 2, "R8");
        enable = 1'b0;
        expect_pat(3'b011, dly(2'd1, 4'd1, 1) + 2, "R8 first fall");
        enable = 1'b1;
        expect_pat(3'b001, dly(2'd1, 4'd3, 0) + 1, "R8 fall continues with enable high");
        expect_pat(3'b000, dly(2'd1, 4'd2, 0) + 1, "R8 power-down completes");
        expect_pat(3'b001, dly(2'd1, 4'd1, 1) + 2, "R8 new power-up from idle");
        enable = 1'b0;

        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule